// File: doc/BRIEF.md
# Leveled Priority Interrupt Controller

The controller collects eight interrupt requests and presents a single interrupt level to a processor core. Four requests come from asynchronous pins, and four come from on-chip peripherals. Each source has its own control word, which gives:

- an interrupt level from 1 to 7 (level 0 switches the source off);
- a priority from 0 to 3 that ranks sources sharing a level;
- a choice between an automatically generated vector and a programmed vector;
- for pin sources only, a choice between level-sensitive and edge-latched capture.

A separate mask word can block any source. A live view of the pending sources is available at all times.

Arbitration works in two tiers. The highest level wins first. Within that level, the higher priority wins, and an exact tie goes to the lower source index. The resulting level is compared with the core's current mask. Level 7 always passes this comparison, which makes it the non-maskable path, for example for a watchdog timeout routed to a peripheral input. When the core runs an acknowledge cycle for a level, the controller picks the winner at that level. One cycle later it returns that source's vector, or the spurious vector if nothing is pending at the acknowledged level. An edge-latched request is cleared by its own acknowledge.

Top module: `lpic_top`

## Requirements
- R1: After synchronous reset, `irq_level_o`, `vec_vld_o`, `pend_o` and `cfg_rdata_o` are all zero.
- R2: A pin source in level mode shows in `pend_o` two clock edges after its input is sampled high. In edge mode it shows three edges after the rising edge. Peripheral inputs show in `pend_o` combinationally.
- R3: A source with level field 0, or with its mask bit (bit index = source index) set, never contributes to `irq_level_o` or to an acknowledge. It may still show in `pend_o`.
- R4: `irq_level_o` equals the highest level among enabled, unmasked, pending sources when that level is above `core_mask_i`, and 0 otherwise.
- R5: In an acknowledge, the higher priority wins among sources at the acknowledged level. An exact level and priority tie goes to the lower source index (pins are indices 0-3, peripherals 4-7).
- R6: The edge after `iack_i` is sampled high, `vec_vld_o` rises for exactly that cycle. `vec_o` is then 24 plus the level if the winner's autovector bit is set, and the winner's programmed vector otherwise.
- R7: When no eligible source is pending at the acknowledged level (including level 0), the returned vector is the spurious vector 24.
- R8: An edge-latched request stays pending after its pin falls, until the acknowledge that selects it. A level-mode request does not latch.
- R9: The control word layout is: bits [2:0] level, [4:3] priority, [5] autovector select, [6] edge mode, [7] reads 0, [15:8] vector. Writing it sets the source chosen by `cfg_idx_i`, and `cfg_rdata_o` returns the word for that index. Bit 6 always reads 0 for peripheral sources (4-7).
- R10: A level-7 winner is presented even when `core_mask_i` is 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_irq_i | input | 4 | Asynchronous pin requests, sources 0-3 |
| int_irq_i | input | 4 | Synchronous peripheral requests, sources 4-7 |
| core_mask_i | input | 3 | Core's current interrupt mask level |
| cfg_wr_i | input | 1 | Write strobe for a control word |
| cfg_idx_i | input | 3 | Source index for control word write and read |
| cfg_wdata_i | input | 16 | Control word to write |
| cfg_rdata_o | output | 16 | Control word of source `cfg_idx_i` |
| mask_wr_i | input | 1 | Write strobe for the mask word |
| mask_wdata_i | input | 8 | Mask word, one bit per source, 1 blocks |
| pend_o | output | 8 | Pending status per source |
| irq_level_o | output | 3 | Level presented to the core, 0 for none |
| iack_i | input | 1 | Acknowledge request, one cycle |
| iack_level_i | input | 3 | Level being acknowledged |
| vec_vld_o | output | 1 | Vector valid, one cycle after acknowledge |
| vec_o | output | 8 | Returned vector number |

## Verification
The assertions assume that reset is applied at the start and that the control inputs are never X after reset. The response assertions also assume that a single `iack_i` cycle produces exactly one valid cycle, so they do not depend on how acknowledges are spaced. The stimulus drives every input one time unit after the rising edge and holds it for the whole cycle. The random phase acknowledges at arbitrary levels, including back-to-back and level-0 cycles, and a behavioural model tracks the resulting latch clears. Pin inputs are treated as already asynchronous, so glitches shorter than a cycle are outside the stimulus.

// File: rtl/lpic_pkg.sv
package lpic_pkg;

    localparam int N_EXT = 4;
    localparam int N_INT = 4;
    localparam int N_SRC = N_EXT + N_INT;
    localparam int IDX_W = $clog2(N_SRC);
    localparam int LVL_W = 3;
    localparam int PRI_W = 2;
    localparam int VEC_W = 8;
    localparam int CFG_W = VEC_W + 2 + 1 + PRI_W + LVL_W;
    localparam int KEY_W = LVL_W + PRI_W + IDX_W;

    localparam logic [VEC_W-1:0] AUTOVEC_BASE = VEC_W'(24);
    localparam logic [LVL_W-1:0] NMI_LVL      = '1;

    typedef logic [LVL_W-1:0] lvl_t;
    typedef logic [PRI_W-1:0] pri_t;
    typedef logic [IDX_W-1:0] idx_t;
    typedef logic [VEC_W-1:0] vec_t;

    // Control word for one source; field order sets bit positions
    typedef struct packed {
        vec_t vector;
        logic rsvd;
        logic edge_mode;
        logic use_auto;
        pri_t prio;
        lvl_t level;
    } src_cfg_t;

    // Ranking key: level first, then priority, then lower index
    function automatic logic [KEY_W-1:0] rank_key(lvl_t l, pri_t p, idx_t i);
        return {l, p, ~i};
    endfunction

    function automatic vec_t autovec(lvl_t l);
        return AUTOVEC_BASE + VEC_W'(l);
    endfunction

endpackage

// File: rtl/lpic_pin_capture.sv
module lpic_pin_capture
    import lpic_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    input  logic edge_mode,
    input  logic ack_clr,
    output logic pend_o
);

    logic meta_q;
    logic sync_q;
    logic sync_d;
    logic latch_q;
    logic rise;

    assign rise = sync_q & ~sync_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q  <= 1'b0;
            sync_q  <= 1'b0;
            sync_d  <= 1'b0;
            latch_q <= 1'b0;
        end else begin
            meta_q <= async_in;
            sync_q <= meta_q;
            sync_d <= sync_q;
            if (!edge_mode)
                latch_q <= 1'b0;
            else if (rise)
                latch_q <= 1'b1;
            else if (ack_clr)
                latch_q <= 1'b0;
        end
    end

    assign pend_o = edge_mode ? latch_q : sync_q;

    // R8
    latch_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (edge_mode && latch_q && !ack_clr) |=> latch_q);

    // R2
    edge_capture_chk: assert property (@(posedge clk) disable iff (rst)
        (edge_mode && rise) |=> latch_q);

endmodule

// File: rtl/lpic_cfg_regs.sv
module lpic_cfg_regs
    import lpic_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_i,
    input  idx_t             idx_i,
    input  logic [CFG_W-1:0] wdata_i,
    output logic [CFG_W-1:0] rdata_o,
    input  logic             mask_wr_i,
    input  logic [N_SRC-1:0] mask_wdata_i,
    output src_cfg_t         cfg_o [N_SRC],
    output logic [N_SRC-1:0] mask_o
);

    src_cfg_t cfg_q [N_SRC];
    src_cfg_t wr_word;

    assign wr_word = src_cfg_t'(wdata_i);

    for (genvar g = 0; g < N_SRC; g++) begin : g_src
        always_ff @(posedge clk) begin
            if (rst) begin
                cfg_q[g] <= '0;
            end else if (wr_i && idx_i == idx_t'(g)) begin
                cfg_q[g]      <= wr_word;
                cfg_q[g].rsvd <= 1'b0;
                if (g >= N_EXT)
                    cfg_q[g].edge_mode <= 1'b0;
            end
        end
        assign cfg_o[g] = cfg_q[g];

        // R9
        int_edge_zero_chk: assert property (@(posedge clk) disable iff (rst)
            (g >= N_EXT) |-> !cfg_q[g].edge_mode);
    end

    always_ff @(posedge clk) begin
        if (rst)
            mask_o <= '0;
        else if (mask_wr_i)
            mask_o <= mask_wdata_i;
    end

    assign rdata_o = cfg_q[idx_i];

endmodule

// File: rtl/lpic_arbiter.sv
module lpic_arbiter
    import lpic_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [N_SRC-1:0] req_i,
    input  lvl_t             lvl_i [N_SRC],
    input  pri_t             pri_i [N_SRC],
    input  logic             filt_en_i,
    input  lvl_t             filt_lvl_i,
    output logic             found_o,
    output idx_t             win_idx_o,
    output lvl_t             win_lvl_o
);

    always_comb begin
        logic [KEY_W-1:0] best;
        logic [KEY_W-1:0] key;
        logic             ok;
        found_o   = 1'b0;
        win_idx_o = '0;
        best      = '0;
        for (int i = 0; i < N_SRC; i++) begin
            key = rank_key(lvl_i[i], pri_i[i], idx_t'(i));
            ok  = req_i[i] && (lvl_i[i] != '0) &&
                  (!filt_en_i || lvl_i[i] == filt_lvl_i);
            if (ok && (!found_o || key > best)) begin
                found_o   = 1'b1;
                best      = key;
                win_idx_o = idx_t'(i);
            end
        end
    end

    assign win_lvl_o = found_o ? lvl_i[win_idx_o] : '0;

    // R3
    win_requesting_chk: assert property (@(posedge clk) disable iff (rst)
        found_o |-> (req_i[win_idx_o] && win_lvl_o != '0));

    // R5
    win_level_match_chk: assert property (@(posedge clk) disable iff (rst)
        (found_o && filt_en_i) |-> (win_lvl_o == filt_lvl_i));

endmodule

// File: rtl/lpic_ack_unit.sv
module lpic_ack_unit
    import lpic_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             iack_i,
    input  logic             found_i,
    input  idx_t             win_idx_i,
    input  lvl_t             win_lvl_i,
    input  logic             win_auto_i,
    input  vec_t             win_vec_i,
    output logic             vec_vld_o,
    output vec_t             vec_o,
    output logic [N_SRC-1:0] clr_o
);

    vec_t next_vec;

    always_comb begin
        if (!found_i)
            next_vec = AUTOVEC_BASE;
        else if (win_auto_i)
            next_vec = autovec(win_lvl_i);
        else
            next_vec = win_vec_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vec_vld_o <= 1'b0;
            vec_o     <= '0;
        end else begin
            vec_vld_o <= iack_i;
            if (iack_i)
                vec_o <= next_vec;
        end
    end

    always_comb begin
        clr_o = '0;
        if (iack_i && found_i)
            clr_o[win_idx_i] = 1'b1;
    end

    // R6
    vld_follows_ack_chk: assert property (@(posedge clk) disable iff (rst)
        iack_i |=> vec_vld_o);

    // R6
    vld_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !iack_i |=> !vec_vld_o);

    // R7
    spurious_vec_chk: assert property (@(posedge clk) disable iff (rst)
        (iack_i && !found_i) |=> (vec_o == AUTOVEC_BASE));

    // R8
    single_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(clr_o));

endmodule

// File: rtl/lpic_top.sv
module lpic_top
    import lpic_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [N_EXT-1:0] ext_irq_i,
    input  logic [N_INT-1:0] int_irq_i,
    input  logic [LVL_W-1:0] core_mask_i,
    input  logic             cfg_wr_i,
    input  logic [IDX_W-1:0] cfg_idx_i,
    input  logic [CFG_W-1:0] cfg_wdata_i,
    output logic [CFG_W-1:0] cfg_rdata_o,
    input  logic             mask_wr_i,
    input  logic [N_SRC-1:0] mask_wdata_i,
    output logic [N_SRC-1:0] pend_o,
    output logic [LVL_W-1:0] irq_level_o,
    input  logic             iack_i,
    input  logic [LVL_W-1:0] iack_level_i,
    output logic             vec_vld_o,
    output logic [VEC_W-1:0] vec_o
);

    src_cfg_t         cfg [N_SRC];
    logic [N_SRC-1:0] mask;
    logic [N_SRC-1:0] clr;
    logic [N_EXT-1:0] ext_pend;
    logic [N_SRC-1:0] req;
    lvl_t             lvl_arr [N_SRC];
    pri_t             pri_arr [N_SRC];

    logic pres_found;
    idx_t pres_idx;
    lvl_t pres_lvl;
    logic ack_found;
    idx_t ack_idx;
    lvl_t ack_lvl;

    lpic_cfg_regs u_regs (
        .clk          (clk),
        .rst          (rst),
        .wr_i         (cfg_wr_i),
        .idx_i        (cfg_idx_i),
        .wdata_i      (cfg_wdata_i),
        .rdata_o      (cfg_rdata_o),
        .mask_wr_i    (mask_wr_i),
        .mask_wdata_i (mask_wdata_i),
        .cfg_o        (cfg),
        .mask_o       (mask)
    );

    for (genvar g = 0; g < N_EXT; g++) begin : g_pin
        lpic_pin_capture u_cap (
            .clk       (clk),
            .rst       (rst),
            .async_in  (ext_irq_i[g]),
            .edge_mode (cfg[g].edge_mode),
            .ack_clr   (clr[g]),
            .pend_o    (ext_pend[g])
        );
    end

    for (genvar g = 0; g < N_SRC; g++) begin : g_fld
        assign lvl_arr[g] = cfg[g].level;
        assign pri_arr[g] = cfg[g].prio;
    end

    assign pend_o = {int_irq_i, ext_pend};
    assign req    = pend_o & ~mask;

    lpic_arbiter u_present (
        .clk        (clk),
        .rst        (rst),
        .req_i      (req),
        .lvl_i      (lvl_arr),
        .pri_i      (pri_arr),
        .filt_en_i  (1'b0),
        .filt_lvl_i ('0),
        .found_o    (pres_found),
        .win_idx_o  (pres_idx),
        .win_lvl_o  (pres_lvl)
    );

    lpic_arbiter u_select (
        .clk        (clk),
        .rst        (rst),
        .req_i      (req),
        .lvl_i      (lvl_arr),
        .pri_i      (pri_arr),
        .filt_en_i  (1'b1),
        .filt_lvl_i (iack_level_i),
        .found_o    (ack_found),
        .win_idx_o  (ack_idx),
        .win_lvl_o  (ack_lvl)
    );

    assign irq_level_o = (pres_lvl == NMI_LVL || pres_lvl > core_mask_i) ? pres_lvl : '0;

    lpic_ack_unit u_ack (
        .clk        (clk),
        .rst        (rst),
        .iack_i     (iack_i),
        .found_i    (ack_found),
        .win_idx_i  (ack_idx),
        .win_lvl_i  (ack_lvl),
        .win_auto_i (cfg[ack_idx].use_auto),
        .win_vec_i  (cfg[ack_idx].vector),
        .vec_vld_o  (vec_vld_o),
        .vec_o      (vec_o),
        .clr_o      (clr)
    );

    // R4
    above_mask_chk: assert property (@(posedge clk) disable iff (rst)
        (irq_level_o != '0) |-> (irq_level_o == NMI_LVL || irq_level_o > core_mask_i));

    // R10
    nmi_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (pres_found && !mask[pres_idx] && pres_lvl == NMI_LVL) |-> (irq_level_o == NMI_LVL));

    // R3
    no_req_no_level_chk: assert property (@(posedge clk) disable iff (rst)
        (req == '0) |-> (irq_level_o == '0));

endmodule

// File: tb/tb_lpic_top.sv
`timescale 1ns/1ps
module tb_lpic_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  ext_irq = '0;
    logic [3:0]  int_irq = '0;
    logic [2:0]  core_mask = '0;
    logic        cfg_wr = 1'b0;
    logic [2:0]  cfg_idx = '0;
    logic [15:0] cfg_wdata = '0;
    logic [15:0] cfg_rdata;
    logic        mask_wr = 1'b0;
    logic [7:0]  mask_wdata = '0;
    logic [7:0]  pend;
    logic [2:0]  irq_level;
    logic        iack = 1'b0;
    logic [2:0]  iack_level = '0;
    logic        vec_vld;
    logic [7:0]  vec;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;
    string phase = "R1";

    always #2.5 clk = ~clk;

    lpic_top dut (
        .clk(clk), .rst(rst), .ext_irq_i(ext_irq), .int_irq_i(int_irq),
        .core_mask_i(core_mask), .cfg_wr_i(cfg_wr), .cfg_idx_i(cfg_idx),
        .cfg_wdata_i(cfg_wdata), .cfg_rdata_o(cfg_rdata), .mask_wr_i(mask_wr),
        .mask_wdata_i(mask_wdata), .pend_o(pend), .irq_level_o(irq_level),
        .iack_i(iack), .iack_level_i(iack_level), .vec_vld_o(vec_vld), .vec_o(vec)
    );

    // ---------------- behavioural reference model ----------------
    int m_lvl [8];
    int m_pri [8];
    int m_av  [8];
    int m_edg [8];
    int m_vec [8];
    bit m_msk [8];
    bit s1 [4];
    bit s2 [4];
    bit s3 [4];
    bit lat [4];
    bit m_vv;
    int m_vo;

    function automatic bit m_pend(int i);
        if (i < 4) return (m_edg[i] != 0) ? lat[i] : s2[i];
        return int_irq[i-4];
    endfunction

    function automatic int m_best(int filt);
        int b = -1;
        for (int i = 0; i < 8; i++) begin
            if (m_pend(i) && !m_msk[i] && m_lvl[i] != 0 && (filt < 0 || m_lvl[i] == filt)) begin
                if (b < 0 || m_lvl[i] > m_lvl[b] || (m_lvl[i] == m_lvl[b] && m_pri[i] > m_pri[b]))
                    b = i;
            end
        end
        return b;
    endfunction

    function automatic int m_irq();
        int b = m_best(-1);
        int l = (b < 0) ? 0 : m_lvl[b];
        return (l == 7 || l > int'(core_mask)) ? l : 0;
    endfunction

    always @(posedge clk) begin : model
        int w;
        w = -1;
        if (rst) begin
            for (int i = 0; i < 8; i++) begin
                m_lvl[i] = 0; m_pri[i] = 0; m_av[i] = 0; m_edg[i] = 0; m_vec[i] = 0; m_msk[i] = 0;
            end
            for (int i = 0; i < 4; i++) begin
                s1[i] = 0; s2[i] = 0; s3[i] = 0; lat[i] = 0;
            end
            m_vv = 0; m_vo = 0;
        end else begin
            if (iack) begin
                w = m_best(int'(iack_level));
                m_vv = 1;
                m_vo = (w < 0) ? 24 : ((m_av[w] != 0) ? 24 + m_lvl[w] : m_vec[w]);
            end else begin
                m_vv = 0;
            end
            for (int i = 0; i < 4; i++) begin
                if (m_edg[i] == 0) lat[i] = 0;
                else if (s2[i] && !s3[i]) lat[i] = 1;
                else if (w == i) lat[i] = 0;
                s3[i] = s2[i]; s2[i] = s1[i]; s1[i] = ext_irq[i];
            end
            if (cfg_wr) begin
                m_lvl[cfg_idx] = int'(cfg_wdata[2:0]);
                m_pri[cfg_idx] = int'(cfg_wdata[4:3]);
                m_av[cfg_idx]  = int'(cfg_wdata[5]);
                m_edg[cfg_idx] = (cfg_idx < 4) ? int'(cfg_wdata[6]) : 0;
                m_vec[cfg_idx] = int'(cfg_wdata[15:8]);
            end
            if (mask_wr)
                for (int i = 0; i < 8; i++) m_msk[i] = mask_wdata[i];
        end
    end

    task automatic check(bit ok, string what, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s (%s) actual %0d expected %0d", what, phase, act, exp);
        end
    endtask

    // per-cycle comparison against the model, sampled mid-cycle
    always @(negedge clk) begin
        if (!rst && !done) begin
            int ep;
            int er;
            ep = 0;
            for (int i = 0; i < 8; i++) if (m_pend(i)) ep |= (1 << i);
            check(int'(pend) == ep, "R2 pend_o", int'(pend), ep);
            check(int'(irq_level) == m_irq(), "R4 irq_level_o", int'(irq_level), m_irq());
            check(vec_vld == m_vv, "R6 vec_vld_o", int'(vec_vld), int'(m_vv));
            if (m_vv) check(int'(vec) == m_vo, "R6 vec_o", int'(vec), m_vo);
            er = (m_vec[cfg_idx] << 8) | (m_edg[cfg_idx] << 6) | (m_av[cfg_idx] << 5) |
                 (m_pri[cfg_idx] << 3) | m_lvl[cfg_idx];
            check(int'(cfg_rdata) == er, "R9 cfg_rdata_o", int'(cfg_rdata), er);
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic tick(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wcfg(int idx, int lvl, int pri, int av, int edg, int v);
        @(posedge clk); #1;
        cfg_wr = 1'b1; cfg_idx = 3'(idx);
        cfg_wdata = {8'(v), 1'b0, 1'(edg), 1'(av), 2'(pri), 3'(lvl)};
        @(posedge clk); #1;
        cfg_wr = 1'b0;
    endtask

    task automatic wmask(int m);
        @(posedge clk); #1;
        mask_wr = 1'b1; mask_wdata = 8'(m);
        @(posedge clk); #1;
        mask_wr = 1'b0;
    endtask

    task automatic do_ack(int lvl, int exp, string what);
        @(posedge clk); #1;
        iack = 1'b1; iack_level = 3'(lvl);
        @(posedge clk); #1;
        iack = 1'b0;
        check(vec_vld == 1'b1, {what, " valid"}, int'(vec_vld), 1);
        check(int'(vec) == exp, what, int'(vec), exp);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog expired (%s) actual 1 expected 0", phase);
            finish_run();
        end
    end

    initial begin
        tick(3);
        rst = 1'b0;
        #1;
        phase = "R1";
        check(irq_level == 3'd0, "R1 reset irq_level_o", int'(irq_level), 0);
        check(vec_vld == 1'b0, "R1 reset vec_vld_o", int'(vec_vld), 0);
        check(pend == 8'd0, "R1 reset pend_o", int'(pend), 0);
        check(cfg_rdata == 16'd0, "R1 reset cfg_rdata_o", int'(cfg_rdata), 0);

        phase = "R9";
        wcfg(0, 3, 1, 0, 0, 8'h40);
        wcfg(1, 3, 2, 1, 0, 8'h41);
        wcfg(2, 5, 0, 0, 1, 8'h42);
        wcfg(3, 0, 3, 0, 0, 8'h43);
        wcfg(4, 3, 2, 0, 1, 8'h44);
        wcfg(5, 7, 0, 1, 0, 8'h45);
        wcfg(6, 6, 1, 0, 0, 8'h46);
        wcfg(7, 2, 3, 0, 0, 8'h47);
        cfg_idx = 3'd4; #1;
        check(cfg_rdata == 16'h4413, "R9 peripheral edge bit reads 0", int'(cfg_rdata), 16'h4413);
        cfg_idx = 3'd2; #1;
        check(cfg_rdata == 16'h4245, "R9 pin word readback", int'(cfg_rdata), 16'h4245);

        phase = "R2";
        ext_irq[0] = 1'b1;
        tick(1);
        check(pend[0] == 1'b0, "R2 level mode after one edge", int'(pend[0]), 0);
        tick(1);
        check(pend[0] == 1'b1, "R2 level mode after two edges", int'(pend[0]), 1);
        ext_irq[0] = 1'b0;
        ext_irq[2] = 1'b1;
        tick(2);
        check(pend[2] == 1'b0, "R2 edge mode after two edges", int'(pend[2]), 0);
        tick(1);
        check(pend[2] == 1'b1, "R2 edge mode after three edges", int'(pend[2]), 1);
        ext_irq[2] = 1'b0;
        do_ack(5, 8'h42, "R6 programmed vector");
        tick(3);

        phase = "R3";
        ext_irq[3] = 1'b1;
        tick(5);
        check(pend[3] == 1'b1, "R3 level-0 source pending", int'(pend[3]), 1);
        check(irq_level == 3'd0, "R3 level-0 source ignored", int'(irq_level), 0);
        ext_irq[3] = 1'b0;
        wmask(8'h40);
        int_irq[2] = 1'b1;
        tick(1);
        check(irq_level == 3'd0, "R3 masked source ignored", int'(irq_level), 0);
        do_ack(6, 24, "R3 masked source not acknowledged");
        wmask(8'h00);
        tick(1);
        check(irq_level == 3'd6, "R3 unmasked source presented", int'(irq_level), 6);
        int_irq[2] = 1'b0;

        phase = "R4";
        int_irq[3] = 1'b1;
        core_mask = 3'd3; tick(1);
        check(irq_level == 3'd0, "R4 below core mask", int'(irq_level), 0);
        core_mask = 3'd2; tick(1);
        check(irq_level == 3'd0, "R4 equal to core mask", int'(irq_level), 0);
        core_mask = 3'd1; tick(1);
        check(irq_level == 3'd2, "R4 above core mask", int'(irq_level), 2);
        int_irq[3] = 1'b0; core_mask = 3'd0;

        phase = "R10";
        core_mask = 3'd7;
        int_irq[1] = 1'b1; tick(1);
        check(irq_level == 3'd7, "R10 level 7 passes mask 7", int'(irq_level), 7);
        do_ack(7, 31, "R10 level 7 autovector");
        int_irq[1] = 1'b0; int_irq[2] = 1'b1; tick(1);
        check(irq_level == 3'd0, "R10 level 6 blocked by mask 7", int'(irq_level), 0);
        int_irq[2] = 1'b0; core_mask = 3'd0;

        phase = "R5";
        ext_irq[0] = 1'b1; ext_irq[1] = 1'b1;
        tick(4);
        do_ack(3, 27, "R5 higher priority autovector");
        ext_irq[1] = 1'b0; int_irq[0] = 1'b1;
        tick(4);
        do_ack(3, 8'h44, "R5 peripheral wins on priority");
        wcfg(0, 3, 2, 0, 0, 8'h40);
        do_ack(3, 8'h40, "R5 tie to lower index");
        ext_irq[0] = 1'b0; int_irq[0] = 1'b0;
        tick(4);

        phase = "R7";
        do_ack(4, 24, "R7 empty level spurious");
        do_ack(0, 24, "R7 level 0 spurious");

        phase = "R8";
        ext_irq[2] = 1'b1; tick(1); ext_irq[2] = 1'b0;
        tick(6);
        check(pend[2] == 1'b1, "R8 edge latch holds", int'(pend[2]), 1);
        check(irq_level == 3'd5, "R8 latched level presented", int'(irq_level), 5);
        do_ack(5, 8'h42, "R8 latched source acknowledged");
        check(pend[2] == 1'b0, "R8 latch cleared by acknowledge", int'(pend[2]), 0);
        ext_irq[0] = 1'b1; tick(1); ext_irq[0] = 1'b0;
        tick(6);
        check(pend[0] == 1'b0, "R8 level mode does not latch", int'(pend[0]), 0);

        phase = "random";
        for (int k = 0; k < 3000; k++) begin
            @(posedge clk); #1;
            ext_irq   = 4'($urandom);
            int_irq   = 4'($urandom) & 4'($urandom);
            core_mask = 3'($urandom);
            iack       = ($urandom % 4) == 0;
            iack_level = 3'($urandom);
            cfg_wr     = ($urandom % 16) == 0;
            cfg_idx    = 3'($urandom);
            cfg_wdata  = 16'($urandom);
            mask_wr    = ($urandom % 32) == 0;
            mask_wdata = 8'($urandom) & 8'($urandom);
        end
        @(posedge clk); #1;
        iack = 1'b0; cfg_wr = 1'b0; mask_wr = 1'b0;
        tick(2);
        finish_run();
    end

endmodule